// File: doc/BRIEF.md
# Byte Bit-Manipulation Execution Unit

This execution unit applies a single-bit operation to a byte operand that the datapath has already fetched. Four operations edit the byte: force a bit high, force a bit low, flip it, or only test it. The other four fold the addressed bit, or its complement, into a carry flag with AND or OR. Chains of these carry operations let software evaluate boolean expressions over scattered bits, with the carry flag as the accumulator.

The bit position comes from a 3-bit immediate or from the low three bits of a general-register value. A source-select input chooses between them. The modified byte and a write-back enable are combinational outputs, so the surrounding pipeline stage can store the byte in the same cycle. The zero and carry flags are registers inside the unit and update on the clock edge when a valid strobe is high. Two operations, the inverted carry-AND and the inverted carry-OR, may take their bit number only from the immediate. If either is presented with the register source, the unit flags it as illegal and does nothing.

Top module: `bit_manip_unit`

## Requirements
- R1: A synchronous, active-high reset clears both the zero flag `z_o` and the carry flag `c_o` to 0.
- R2: The bit number is `imm_i` when `src_reg_i` is 0 and `gpr_i[2:0]` when `src_reg_i` is 1. All `gpr_i` bits above bit 2 are ignored, so a register value of 0x000D addresses bit 5.
- R3: Opcode 0 (set) gives `result_o` equal to the operand with the addressed bit forced to 1 and every other bit unchanged, and it asserts `wb_en_o`.
- R4: Opcode 1 (clear) gives `result_o` equal to the operand with the addressed bit forced to 0 and every other bit unchanged, and it asserts `wb_en_o`.
- R5: Opcode 2 (invert) gives `result_o` equal to the operand with the addressed bit complemented and every other bit unchanged, and it asserts `wb_en_o`.
- R6: Opcode 3 (test) loads `z_o` with the complement of the addressed bit at the next clock edge, so `z_o` becomes 1 when that bit is 0.
- R7: Opcode 4 loads `c_o` with `c_o AND bit`, and opcode 6 loads `c_o` with `c_o OR bit`, at the next clock edge. Either bit-number source is accepted.
- R8: With the immediate source, opcode 5 loads `c_o` with `c_o AND NOT bit`, and opcode 7 loads `c_o` with `c_o OR NOT bit`.
- R9: Opcode 5 or 7 presented with `valid_i`=1 and `src_reg_i`=1 drives `illegal_o` to 1. In that case `wb_en_o` stays 0 and both flags keep their values.
- R10: `wb_en_o` is 1 only when `valid_i` is 1 and the opcode is 0, 1 or 2. Whenever `wb_en_o` is 0, `result_o` equals `opnd_i`.
- R11: `z_o` changes only after a valid test, and `c_o` changes only after a valid, legal opcode 4 to 7. With `valid_i` at 0, neither flag changes.
- R12: `illegal_o` is 0 for every combination other than the one described in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code, 0 to 7 |
| opnd_i | input | 8 | Byte operand |
| imm_i | input | 3 | Immediate bit number |
| gpr_i | input | 16 | General-register value; only bits 2:0 are used |
| src_reg_i | input | 1 | 1 selects the register bit number |
| result_o | output | 8 | Modified byte, or the operand unchanged |
| wb_en_o | output | 1 | Write back `result_o` |
| illegal_o | output | 1 | Illegal bit-number source for an inverted carry operation |
| z_o | output | 1 | Zero flag register |
| c_o | output | 1 | Carry flag register |

## Verification
The bench builds the default 8-bit, 16-bit-register configuration twice. One copy uses the per-bit editing variant and the other uses the mask variant. Because the operand is only eight bits wide, every operand value can be swept against all eight bit positions, both bit-number sources and all eight opcodes. Each vector drives different values on the immediate and on the register's low bits, so an error in the source select shows up in the result. The sweep interleaves the opcodes, which leaves the carry flag in both states before every carry operation. Idle vectors and a reset taken while both flags are set show that the flags hold and that they clear.

// File: rtl/bm_pkg.sv
package bm_pkg;

   typedef enum logic [2:0] {
      BM_SET   = 3'd0,
      BM_CLR   = 3'd1,
      BM_INV   = 3'd2,
      BM_TST   = 3'd3,
      BM_CAND  = 3'd4,
      BM_CANDN = 3'd5,
      BM_COR   = 3'd6,
      BM_CORN  = 3'd7
   } bm_op_e;

   function automatic logic bm_edits(input bm_op_e op);
      return (op == BM_SET) || (op == BM_CLR) || (op == BM_INV);
   endfunction

   function automatic logic bm_carry(input bm_op_e op);
      return op[2];
   endfunction

   function automatic logic bm_inverse(input bm_op_e op);
      return (op == BM_CANDN) || (op == BM_CORN);
   endfunction

endpackage

// File: rtl/bm_bitpos.sv
module bm_bitpos
   import bm_pkg::*;
#(
   parameter int IDX_W = 3,
   parameter int REG_W = 16
) (
   input  logic             valid_i,
   input  bm_op_e           op_i,
   input  logic [IDX_W-1:0] imm_i,
   input  logic [REG_W-1:0] gpr_i,
   input  logic             src_reg_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             illegal_o
);

   if (REG_W < IDX_W) begin : g_bad_reg
      $error("bm_bitpos: REG_W must be at least IDX_W");
   end

   if (REG_W > IDX_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^gpr_i[REG_W-1:IDX_W];
   end

   assign idx_o     = src_reg_i ? gpr_i[IDX_W-1:0] : imm_i;
   assign illegal_o = valid_i && src_reg_i && bm_inverse(op_i);

endmodule

// File: rtl/bm_alter.sv
module bm_alter
   import bm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3,
   parameter int STYLE  = 0
) (
   input  logic              en_i,
   input  bm_op_e            op_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [DATA_W-1:0] res_o,
   output logic              bit_o
);

   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("bm_alter: STYLE must be 0 or 1");
   end

   assign bit_o = opnd_i[idx_i];

   if (STYLE == 0) begin : g_perbit
      for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
         logic hit;
         assign hit = en_i && (idx_i == IDX_W'(gi));
         always_comb begin
            res_o[gi] = opnd_i[gi];
            if (hit) begin
               case (op_i)
                  BM_SET:  res_o[gi] = 1'b1;
                  BM_CLR:  res_o[gi] = 1'b0;
                  BM_INV:  res_o[gi] = ~opnd_i[gi];
                  default: res_o[gi] = opnd_i[gi];
               endcase
            end
         end
      end
   end else begin : g_mask
      logic [DATA_W-1:0] mask;
      assign mask = en_i ? (DATA_W'(1) << idx_i) : '0;
      always_comb begin
         case (op_i)
            BM_SET:  res_o = opnd_i | mask;
            BM_CLR:  res_o = opnd_i & ~mask;
            BM_INV:  res_o = opnd_i ^ mask;
            default: res_o = opnd_i;
         endcase
      end
   end

endmodule

// File: rtl/bm_flags.sv
module bm_flags
   import bm_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   valid_i,
   input  bm_op_e op_i,
   input  logic   illegal_i,
   input  logic   bit_i,
   output logic   z_o,
   output logic   c_o
);

   logic z_q, c_q;
   logic go;

   assign go = valid_i && !illegal_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         z_q <= 1'b0;
         c_q <= 1'b0;
      end else if (go) begin
         case (op_i)
            BM_TST:   z_q <= ~bit_i;
            BM_CAND:  c_q <= c_q & bit_i;
            BM_CANDN: c_q <= c_q & ~bit_i;
            BM_COR:   c_q <= c_q | bit_i;
            BM_CORN:  c_q <= c_q | ~bit_i;
            default: ;
         endcase
      end
   end

   assign z_o = z_q;
   assign c_o = c_q;

   // R11
   z_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(valid_i && op_i == BM_TST) |=> $stable(z_q));

   // R11
   c_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(valid_i && !illegal_i && bm_carry(op_i)) |=> $stable(c_q));

   // R6
   z_test_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && op_i == BM_TST) |=> (z_q == !$past(bit_i)));

   // R7
   c_or_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && op_i == BM_COR && bit_i) |=> c_q);

   // R8
   c_andn_chk: assert property (@(posedge clk) disable iff (rst)
      (go && op_i == BM_CANDN && bit_i) |=> !c_q);

endmodule

// File: rtl/bit_manip_unit.sv
module bit_manip_unit
   import bm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int REG_W  = 16,
   parameter int STYLE  = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [$clog2(DATA_W)-1:0] imm_i,
   input  logic [REG_W-1:0]  gpr_i,
   input  logic              src_reg_i,
   output logic [DATA_W-1:0] result_o,
   output logic              wb_en_o,
   output logic              illegal_o,
   output logic              z_o,
   output logic              c_o
);

   localparam int IDX_W = $clog2(DATA_W);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("bit_manip_unit: DATA_W must be a power of two of at least 2");
   end

   bm_op_e           op;
   logic [IDX_W-1:0] idx;
   logic             bit_val;
   logic             edit_en;

   assign op      = bm_op_e'(op_i);
   assign edit_en = valid_i && bm_edits(op);
   assign wb_en_o = edit_en;

   bm_bitpos #(.IDX_W(IDX_W), .REG_W(REG_W)) u_pos (
      .valid_i   (valid_i),
      .op_i      (op),
      .imm_i     (imm_i),
      .gpr_i     (gpr_i),
      .src_reg_i (src_reg_i),
      .idx_o     (idx),
      .illegal_o (illegal_o)
   );

   bm_alter #(.DATA_W(DATA_W), .IDX_W(IDX_W), .STYLE(STYLE)) u_alt (
      .en_i   (edit_en),
      .op_i   (op),
      .opnd_i (opnd_i),
      .idx_i  (idx),
      .res_o  (result_o),
      .bit_o  (bit_val)
   );

   bm_flags u_flg (
      .clk       (clk),
      .rst       (rst),
      .valid_i   (valid_i),
      .op_i      (op),
      .illegal_i (illegal_o),
      .bit_i     (bit_val),
      .z_o       (z_o),
      .c_o       (c_o)
   );

   // R9
   ill_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
      illegal_o |-> !wb_en_o);

   // R9
   ill_flags_chk: assert property (@(posedge clk) disable iff (rst)
      illegal_o |=> ($stable(c_o) && $stable(z_o)));

   // R10
   pass_through_chk: assert property (@(posedge clk) disable iff (rst)
      !wb_en_o |-> (result_o == opnd_i));

   // R3
   single_bit_chk: assert property (@(posedge clk) disable iff (rst)
      wb_en_o |-> ($countones(result_o ^ opnd_i) <= 1));

   // R12
   ill_only_inv_chk: assert property (@(posedge clk) disable iff (rst)
      illegal_o |-> (src_reg_i && op_i[2] && op_i[0]));

endmodule

// File: tb/tb_bit_manip_unit.sv
module tb_bit_manip_unit;

   logic        clk = 1'b0;
   logic        rst, valid, src;
   logic [2:0]  op, imm;
   logic [7:0]  opnd;
   logic [15:0] gpr;
   logic [7:0]  res_a, res_b;
   logic        wb_a, wb_b, ill_a, ill_b, z_a, z_b, c_a, c_b;

   int  n_vec = 0;
   int  n_bad = 0;
   logic mz, mc;

   always #5 clk = ~clk;

   bit_manip_unit #(.DATA_W(8), .REG_W(16), .STYLE(0)) dut (
      .clk(clk), .rst(rst), .valid_i(valid), .op_i(op), .opnd_i(opnd),
      .imm_i(imm), .gpr_i(gpr), .src_reg_i(src), .result_o(res_a),
      .wb_en_o(wb_a), .illegal_o(ill_a), .z_o(z_a), .c_o(c_a));

   bit_manip_unit #(.DATA_W(8), .REG_W(16), .STYLE(1)) dut_m (
      .clk(clk), .rst(rst), .valid_i(valid), .op_i(op), .opnd_i(opnd),
      .imm_i(imm), .gpr_i(gpr), .src_reg_i(src), .result_o(res_b),
      .wb_en_o(wb_b), .illegal_o(ill_b), .z_o(z_b), .c_o(c_b));

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string op_req(input logic [2:0] o);
      case (o)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4, 3'd6: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic apply(input logic v, input logic [2:0] o, input logic [7:0] d,
                        input logic [2:0] p, input logic s);
      logic [7:0] er;
      logic       ewb, eill, b;
      string      rq;
      @(negedge clk);
      valid = v; op = o; opnd = d; src = s;
      if (s) begin
         gpr = {d ^ 8'hA5, 5'(d + 8'(o)), p};
         imm = ~p;
      end else begin
         gpr = {d ^ 8'h5A, 5'(d - 8'(o)), ~p};
         imm = p;
      end
      #1;
      b    = d[p];
      eill = v && s && (o == 3'd5 || o == 3'd7);
      ewb  = v && (o <= 3'd2);
      er   = d;
      if (v) begin
         case (o)
            3'd0: er = d | (8'd1 << p);
            3'd1: er = d & ~(8'd1 << p);
            3'd2: er = d ^ (8'd1 << p);
            default: er = d;
         endcase
      end
      rq = !v ? "R10" : (eill ? "R9" : op_req(o));
      chk(rq, "result", {8'd0, res_a}, {8'd0, er});
      chk(rq, "result_mask", {8'd0, res_b}, {8'd0, er});
      chk("R10", "wb_en", {15'd0, wb_a}, {15'd0, ewb});
      chk("R12", "illegal", {15'd0, ill_a}, {15'd0, eill});
      chk("R12", "illegal_mask", {15'd0, ill_b}, {15'd0, eill});
      @(posedge clk);
      if (v && !eill) begin
         case (o)
            3'd3: mz = ~b;
            3'd4: mc = mc & b;
            3'd5: mc = mc & ~b;
            3'd6: mc = mc | b;
            3'd7: mc = mc | ~b;
            default: ;
         endcase
      end
      #1;
      rq = (!v || o < 3'd3) ? "R11" : rq;
      chk(rq, "z", {15'd0, z_a}, {15'd0, mz});
      chk(rq, "c", {15'd0, c_a}, {15'd0, mc});
      chk(rq, "z_mask", {15'd0, z_b}, {15'd0, mz});
      chk(rq, "c_mask", {15'd0, c_b}, {15'd0, mc});
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst = 1'b1; valid = 1'b0; op = '0; opnd = '0; imm = '0; gpr = '0; src = 1'b0;
      mz = 1'b0; mc = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1", "z after reset", {15'd0, z_a}, 16'd0);
      chk("R1", "c after reset", {15'd0, c_a}, 16'd0);
      @(negedge clk);
      rst = 1'b0;

      // R2: register value 0x000D addresses bit 5
      @(negedge clk);
      valid = 1'b1; op = 3'd0; opnd = 8'h00; src = 1'b1; gpr = 16'h000D; imm = 3'd0;
      #1;
      chk("R2", "reg 0x0D sets bit 5", {8'd0, res_a}, 16'h0020);
      chk("R2", "reg 0x0D sets bit 5 mask", {8'd0, res_b}, 16'h0020);
      gpr = 16'hFFF5;
      #1;
      chk("R2", "upper register bits ignored", {8'd0, res_a}, 16'h0020);
      @(posedge clk);

      // R2..R12 sweep; opcodes interleave so the carry sees both states
      for (int d = 0; d < 256; d++) begin
         for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 2; s++) begin
               for (int o = 0; o < 8; o++) begin
                  apply(1'b1, 3'(o), 8'(d), 3'(p), s[0]);
               end
               // R11 idle vector: no flag may change
               apply(1'b0, 3'(7 - p), 8'(d), 3'(p), s[0]);
            end
         end
      end

      // R1 reset with both flags set
      apply(1'b1, 3'd6, 8'h01, 3'd0, 1'b0);
      apply(1'b1, 3'd3, 8'h00, 3'd4, 1'b0);
      chk("R1", "c set before reset", {15'd0, c_a}, 16'd1);
      chk("R1", "z set before reset", {15'd0, z_a}, 16'd1);
      @(negedge clk);
      valid = 1'b0; rst = 1'b1;
      @(posedge clk);
      #1;
      mz = 1'b0; mc = 1'b0;
      chk("R1", "z cleared by reset", {15'd0, z_a}, 16'd0);
      chk("R1", "c cleared by reset", {15'd0, c_a}, 16'd0);
      @(negedge clk);
      rst = 1'b0;

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule